// File: doc/BRIEF.md
# Charge Threshold Status and Alert Controller

This block watches a 16-bit accumulated charge value against a programmable upper and lower limit and records what it sees in a status byte of sticky flags. Next to the two limit flags it latches an overflow/underflow event, a battery-voltage alert coming from an external comparator, and an undervoltage-recovery event. A flag set by a passing condition stays set until the host reads the status byte and the condition has gone away.

The block also holds the 8-bit control byte and splits it into its fields: battery-voltage level select, prescaler exponent, pin mode and shutdown. The pin mode decides whether the shared pin is driven as an open-drain alert, enabled as a charge-complete input, or left idle. After a successful alert-response on the serial bus, the alert drive is released until a status flag newly sets.

Top module: `chg_alert_ctrl`

## Requirements
- R1: After reset the status byte reads 80h, the control byte reads 3Ch, the upper limit reads FFFFh, the lower limit reads 0000h, the alert drive is off and charge-complete is disabled.
- R2: Status bit 3 sets on the clock edge that follows a cycle with the charge strictly above the upper limit. A charge equal to the limit does not set it.
- R3: Status bit 2 sets on the clock edge that follows a cycle with the charge strictly below the lower limit. A charge equal to the limit does not set it.
- R4: Status bit 5 sets after an overflow/underflow strobe. Status bit 1 sets after a cycle with the battery-low input high while control bits 7:6 are nonzero. With those bits at 00 the battery-low input has no effect.
- R5: Status bit 0 sets after an undervoltage-recovery strobe. Status bit 7 always reads 1, and bits 6 and 4 always read 0.
- R6: A status-read strobe clears each flag whose condition is absent in that cycle. A flag whose condition is present in the read cycle stays set. Without a read, every flag holds.
- R7: With pin mode (control bits 2:1) at 10, the alert drive is on while any of status bits 5, 3, 2 or 1 is set and the alert is not released. Status bit 0 alone does not drive it.
- R8: With pin mode 01, charge-complete enable is 1 and the alert drive is off. With pin mode 00 or 11, both are off.
- R9: An alert-response win strobe releases the alert drive from the next edge on. The release lasts until some status flag goes from 0 to 1. A flag rising in the same cycle as the strobe keeps the alert on.
- R10: The decoded outputs follow the control byte: battery-voltage select is bits 7:6, prescaler exponent is bits 5:3, and shutdown is bit 0.
- R11: A write strobe to the control byte or to either limit makes the new value visible on the edge that completes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| charge_i | input | 16 | Accumulated charge |
| ctrl_wr_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| thr_hi_wr_i | input | 1 | Upper limit write strobe |
| thr_lo_wr_i | input | 1 | Lower limit write strobe |
| thr_wdata_i | input | 16 | Limit write data |
| ovf_evt_i | input | 1 | Overflow/underflow strobe |
| vbat_low_i | input | 1 | Battery-voltage comparator flag |
| uvlo_evt_i | input | 1 | Undervoltage-recovery strobe |
| status_rd_i | input | 1 | Status byte read strobe |
| ara_win_i | input | 1 | Alert-response won by this block |
| status_o | output | 8 | Status byte |
| ctrl_o | output | 8 | Control byte |
| thr_hi_o | output | 16 | Upper limit |
| thr_lo_o | output | 16 | Lower limit |
| vbat_sel_o | output | 2 | Battery-voltage level select |
| presc_exp_o | output | 3 | Prescaler exponent |
| shdn_o | output | 1 | Shutdown request |
| alert_pull_o | output | 1 | Pull the shared pin low |
| cc_en_o | output | 1 | Shared pin acts as charge-complete input |

## Verification
Two collisions matter. A status read can land in the same cycle as a live condition, and an alert-response win can land in the same cycle as a fresh flag rise. The bench causes the first by strobing the read while the charge still sits above the upper limit, and expects the flag to survive. It causes the second by pulsing the overflow strobe in the same cycle as the response win, with all flags clear beforehand, and expects the alert drive to stay on afterwards.

// File: rtl/chg_alert_pkg.sv
package chg_alert_pkg;
   typedef enum logic [1:0] {
      PIN_OFF   = 2'b00,
      PIN_CC    = 2'b01,
      PIN_ALERT = 2'b10,
      PIN_BAD   = 2'b11
   } pin_mode_e;

   // flag vector order inside the block
   localparam int FL_UVLO = 0;
   localparam int FL_VBAT = 1;
   localparam int FL_LO   = 2;
   localparam int FL_HI   = 3;
   localparam int FL_OVF  = 4;
   localparam int NFLAGS  = 5;

   typedef struct packed {
      logic [1:0] vbat_sel;
      logic [2:0] presc_exp;
      logic [1:0] pin_mode;
      logic       shdn;
   } ctrl_t;
endpackage

// File: rtl/chg_thresh_cmp.sv
module chg_thresh_cmp #(
   parameter int CW        = 16,
   parameter bit INCLUSIVE = 1'b0
) (
   input  logic [CW-1:0] charge_i,
   input  logic [CW-1:0] hi_i,
   input  logic [CW-1:0] lo_i,
   output logic          above_o,
   output logic          below_o
);
   generate
      if (INCLUSIVE) begin : g_incl
         assign above_o = (charge_i >= hi_i);
         assign below_o = (charge_i <= lo_i);
      end else begin : g_strict
         assign above_o = (charge_i > hi_i);
         assign below_o = (charge_i < lo_i);
      end
   endgenerate
endmodule

// File: rtl/chg_status_flags.sv
module chg_status_flags #(
   parameter int NF = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] cond_i,
   input  logic          rd_i,
   output logic [NF-1:0] flag_o,
   output logic          rise_o
);
   logic [NF-1:0] rise_v;

   generate
      for (genvar i = 0; i < NF; i++) begin : g_flag
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= 1'b0;
            else if (cond_i[i]) q <= 1'b1;
            else if (rd_i)      q <= 1'b0;
         end
         assign flag_o[i] = q;
         assign rise_v[i] = cond_i[i] & ~q;
      end
   endgenerate

   assign rise_o = |rise_v;
endmodule

// File: rtl/chg_pin_ctrl.sv
module chg_pin_ctrl
   import chg_alert_pkg::*;
#(
   parameter int NF = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  pin_mode_e     mode_i,
   input  logic [NF-1:0] flag_i,
   input  logic          rise_i,
   input  logic          ara_win_i,
   output logic          alert_pull_o,
   output logic          cc_en_o
);
   logic released_q;
   logic any_alert;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         released_q <= 1'b0;
      else if (rise_i)    released_q <= 1'b0;
      else if (ara_win_i) released_q <= 1'b1;
   end

   // undervoltage flag never drives the pin
   assign any_alert = flag_i[FL_VBAT] | flag_i[FL_LO] | flag_i[FL_HI] | flag_i[FL_OVF];

   always_comb begin
      alert_pull_o = 1'b0;
      cc_en_o      = 1'b0;
      unique case (mode_i)
         PIN_ALERT: alert_pull_o = any_alert & ~released_q;
         PIN_CC:    cc_en_o      = 1'b1;
         default:   ;
      endcase
   end
endmodule

// File: rtl/chg_alert_ctrl.sv
module chg_alert_ctrl
   import chg_alert_pkg::*;
#(
   parameter int          CW        = 16,
   parameter logic [7:0]  CTRL_RST  = 8'h3C,
   parameter bit          ID_BIT    = 1'b1,
   parameter bit          INCLUSIVE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] charge_i,
   input  logic          ctrl_wr_i,
   input  logic [7:0]    ctrl_wdata_i,
   input  logic          thr_hi_wr_i,
   input  logic          thr_lo_wr_i,
   input  logic [CW-1:0] thr_wdata_i,
   input  logic          ovf_evt_i,
   input  logic          vbat_low_i,
   input  logic          uvlo_evt_i,
   input  logic          status_rd_i,
   input  logic          ara_win_i,
   output logic [7:0]    status_o,
   output logic [7:0]    ctrl_o,
   output logic [CW-1:0] thr_hi_o,
   output logic [CW-1:0] thr_lo_o,
   output logic [1:0]    vbat_sel_o,
   output logic [2:0]    presc_exp_o,
   output logic          shdn_o,
   output logic          alert_pull_o,
   output logic          cc_en_o
);
   localparam logic [CW-1:0] HI_RST = {CW{1'b1}};
   localparam logic [CW-1:0] LO_RST = {CW{1'b0}};

   generate
      if (CW < 2 || CW > 32) begin : g_bad_cw
         $error("chg_alert_ctrl: CW out of range");
      end
   endgenerate

   ctrl_t         ctrl_q;
   logic [CW-1:0] hi_q, lo_q;
   logic          above, below, rise;
   logic [NFLAGS-1:0] cond, flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= ctrl_t'(CTRL_RST);
         hi_q   <= HI_RST;
         lo_q   <= LO_RST;
      end else begin
         if (ctrl_wr_i)   ctrl_q <= ctrl_t'(ctrl_wdata_i);
         if (thr_hi_wr_i) hi_q   <= thr_wdata_i;
         if (thr_lo_wr_i) lo_q   <= thr_wdata_i;
      end
   end

   chg_thresh_cmp #(.CW(CW), .INCLUSIVE(INCLUSIVE)) u_cmp (
      .charge_i (charge_i),
      .hi_i     (hi_q),
      .lo_i     (lo_q),
      .above_o  (above),
      .below_o  (below)
   );

   always_comb begin
      cond          = '0;
      cond[FL_UVLO] = uvlo_evt_i;
      cond[FL_VBAT] = vbat_low_i & (ctrl_q.vbat_sel != 2'b00);
      cond[FL_LO]   = below;
      cond[FL_HI]   = above;
      cond[FL_OVF]  = ovf_evt_i;
   end

   chg_status_flags #(.NF(NFLAGS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (cond),
      .rd_i   (status_rd_i),
      .flag_o (flags),
      .rise_o (rise)
   );

   chg_pin_ctrl #(.NF(NFLAGS)) u_pin (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_i       (pin_mode_e'(ctrl_q.pin_mode)),
      .flag_i       (flags),
      .rise_i       (rise),
      .ara_win_i    (ara_win_i),
      .alert_pull_o (alert_pull_o),
      .cc_en_o      (cc_en_o)
   );

   assign status_o    = {ID_BIT, 1'b0, flags[FL_OVF], 1'b0,
                         flags[FL_HI], flags[FL_LO], flags[FL_VBAT], flags[FL_UVLO]};
   assign ctrl_o      = ctrl_q;
   assign thr_hi_o    = hi_q;
   assign thr_lo_o    = lo_q;
   assign vbat_sel_o  = ctrl_q.vbat_sel;
   assign presc_exp_o = ctrl_q.presc_exp;
   assign shdn_o      = ctrl_q.shdn;
endmodule

// File: rtl/chg_alert_chk.sv
module chg_alert_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [CW-1:0] charge_i,
   input logic [CW-1:0] thr_hi_o,
   input logic [CW-1:0] thr_lo_o,
   input logic [7:0]    status_o,
   input logic [7:0]    ctrl_o,
   input logic          status_rd_i,
   input logic          ara_win_i,
   input logic          alert_pull_o,
   input logic          cc_en_o
);
   p_id_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[7] && !status_o[6] && !status_o[4]);

   p_hi_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (charge_i > thr_hi_o) |=> status_o[3]);

   p_lo_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (charge_i < thr_lo_o) |=> status_o[2]);

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[3] && !status_rd_i) |=> status_o[3]);

   p_alert_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      alert_pull_o |-> (ctrl_o[2:1] == 2'b10) && (|{status_o[5], status_o[3:1]}));

   p_cc_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cc_en_o |-> (ctrl_o[2:1] == 2'b01) && !alert_pull_o);

   p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ara_win_i |=> (status_o != $past(status_o)) || !alert_pull_o);
endmodule

bind chg_alert_ctrl chg_alert_chk #(.CW(CW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .charge_i     (charge_i),
   .thr_hi_o     (thr_hi_o),
   .thr_lo_o     (thr_lo_o),
   .status_o     (status_o),
   .ctrl_o       (ctrl_o),
   .status_rd_i  (status_rd_i),
   .ara_win_i    (ara_win_i),
   .alert_pull_o (alert_pull_o),
   .cc_en_o      (cc_en_o)
);

// File: tb/chg_alert_ctrl_tb.sv
module chg_alert_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] charge = 16'h7FFF;
   logic        ctrl_wr = 0, thr_hi_wr = 0, thr_lo_wr = 0;
   logic [7:0]  ctrl_wdata = '0;
   logic [15:0] thr_wdata = '0;
   logic        ovf = 0, vbat_low = 0, uvlo = 0, rd = 0, ara = 0;
   logic [7:0]  status, ctrl;
   logic [15:0] thr_hi, thr_lo;
   logic [1:0]  vbat_sel;
   logic [2:0]  presc;
   logic        shdn, alert, cc_en;
   int          checks = 0, errors = 0;

   always #10 clk = ~clk;

   chg_alert_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .charge_i(charge),
      .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
      .thr_hi_wr_i(thr_hi_wr), .thr_lo_wr_i(thr_lo_wr), .thr_wdata_i(thr_wdata),
      .ovf_evt_i(ovf), .vbat_low_i(vbat_low), .uvlo_evt_i(uvlo),
      .status_rd_i(rd), .ara_win_i(ara),
      .status_o(status), .ctrl_o(ctrl), .thr_hi_o(thr_hi), .thr_lo_o(thr_lo),
      .vbat_sel_o(vbat_sel), .presc_exp_o(presc), .shdn_o(shdn),
      .alert_pull_o(alert), .cc_en_o(cc_en)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr_ctrl(logic [7:0] v);
      ctrl_wdata = v; ctrl_wr = 1; step(); ctrl_wr = 0;
   endtask

   task automatic wr_thr(bit hi, logic [15:0] v);
      thr_wdata = v;
      if (hi) thr_hi_wr = 1; else thr_lo_wr = 1;
      step(); thr_hi_wr = 0; thr_lo_wr = 0;
   endtask

   task automatic clear_all();
      charge = 16'h7FFF; vbat_low = 0;
      rd = 1; step(); rd = 0;
   endtask

   task automatic t_reset();
      chk("R1 status", status, 8'h80);
      chk("R1 ctrl", ctrl, 8'h3C);
      chk("R1 hi", thr_hi, 16'hFFFF);
      chk("R1 lo", thr_lo, 16'h0000);
      chk("R1 alert", alert, 0);
      chk("R1 cc", cc_en, 0);
   endtask

   task automatic t_high();
      wr_thr(1, 16'h8000);
      chk("R11 hi write", thr_hi, 16'h8000);
      charge = 16'h8000; step();
      chk("R2 equal no set", status, 8'h80);
      charge = 16'h8001; step();
      chk("R2 above sets", status, 8'h88);
      chk("R7 alert on", alert, 1);
      rd = 1; step(); rd = 0;
      chk("R6 read with live cond keeps", status, 8'h88);
      charge = 16'h7FFF; step(); step();
      chk("R6 no read holds", status, 8'h88);
      rd = 1; step(); rd = 0;
      chk("R6 read clears", status, 8'h80);
      chk("R7 alert off", alert, 0);
   endtask

   task automatic t_low();
      wr_thr(0, 16'h1000);
      chk("R11 lo write", thr_lo, 16'h1000);
      charge = 16'h1000; step();
      chk("R3 equal no set", status, 8'h80);
      charge = 16'h0FFF; step();
      chk("R3 below sets", status, 8'h84);
      clear_all();
      chk("R6 low cleared", status, 8'h80);
   endtask

   task automatic t_events();
      ovf = 1; step(); ovf = 0;
      chk("R4 ovf sets", status, 8'hA0);
      chk("R7 ovf alert", alert, 1);
      clear_all();
      vbat_low = 1; step();
      chk("R4 vbat ignored when off", status, 8'h80);
      vbat_low = 0;
      wr_ctrl(8'h7C);
      vbat_low = 1; step(); vbat_low = 0;
      chk("R4 vbat sets", status, 8'h82);
      clear_all();
      uvlo = 1; step(); uvlo = 0;
      chk("R5 uvlo sets", status, 8'h81);
      chk("R7 uvlo alone no alert", alert, 0);
      clear_all();
      wr_ctrl(8'h3C);
   endtask

   task automatic t_ara();
      charge = 16'h8001; step();
      chk("R9 alert before", alert, 1);
      ara = 1; step(); ara = 0;
      chk("R9 released", alert, 0);
      step();
      chk("R9 stays released", alert, 0);
      ovf = 1; step(); ovf = 0;
      chk("R9 new rise rearms", alert, 1);
      clear_all(); step();
      chk("R9 cleared", status, 8'h80);
      ara = 1; ovf = 1; step(); ara = 0; ovf = 0;
      chk("R9 same-cycle rise wins", alert, 1);
      chk("R9 same-cycle status", status, 8'hA0);
   endtask

   task automatic t_modes();
      ovf = 1; step(); ovf = 0;
      wr_ctrl(8'h3A);
      chk("R8 cc mode cc_en", cc_en, 1);
      chk("R8 cc mode no alert", alert, 0);
      wr_ctrl(8'h38);
      chk("R8 off cc", cc_en, 0);
      chk("R8 off alert", alert, 0);
      wr_ctrl(8'h3E);
      chk("R8 bad cc", cc_en, 0);
      chk("R8 bad alert", alert, 0);
      clear_all();
   endtask

   task automatic t_decode();
      wr_ctrl(8'hA5);
      chk("R11 ctrl write", ctrl, 8'hA5);
      chk("R10 vbat sel", vbat_sel, 2'b10);
      chk("R10 presc", presc, 3'b100);
      chk("R10 shdn", shdn, 1);
      chk("R5 reserved bits", status & 8'hD0, 8'h80);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1; step();
      t_reset();
      t_high();
      t_low();
      t_events();
      t_ara();
      t_modes();
      t_decode();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule